// File: doc/BRIEF.md
# Session-Valid Edge Notification Control Register

This block holds one small control register on the PHY side of a link. The link reaches it through a byte-wide register access port. The register appears at three neighbouring addresses, and the address used picks the kind of write. The first address loads the register. The second sets the bits that are 1 in the data. The third clears the bits that are 1 in the data. A read at any of the three addresses returns the same value. An access can use the short immediate address or the 8-bit extended address. Extended addresses below 40h fold onto the immediate space. Extended addresses from 40h upward are not implemented.

Two bits of the register arm detection of edges on a session-valid level, which arrives asynchronously. A synchronizer first brings that level into the clock domain. When an armed edge is seen, the block raises a request to the downstream status-command serializer, with the alternate-interrupt mark set. The request stays up until the serializer acknowledges it. Edges that arrive while a request is pending merge into that request and are not queued.

Top module: `phy_ctl_regbank`

## Requirements
- R1: After reset the register is 00h, `rd_data` is 00h, and `evt_req`, `evt_alt_int` and `addr_err` are 0.
- R2: A write to 3Dh replaces the register with the write data, keeping only the storable bits 3 and 2.
- R3: A write to 3Eh ORs the storable bits of the write data into the register.
- R4: A write to 3Fh clears every register bit that is 1 in the write data.
- R5: A read at 3Dh, 3Eh or 3Fh returns the register value on `rd_data` after the clock edge that accepts the read. The value then holds until the next read.
- R6: Bits 7..4 and 1..0 always read as 0. Writing 1 to them at any of the three addresses changes nothing.
- R7: When bit 2 is 1, a low-to-high change of `sess_vld_raw` sets `evt_req` on the third rising clock edge after the change. No earlier edge sets it.
- R8: When bit 3 is 1, a high-to-low change of `sess_vld_raw` sets `evt_req` with the same three-edge latency.
- R9: An edge whose enable bit is 0 produces no request.
- R10: `evt_req` stays at 1 until a cycle with `evt_ack` at 1. While it is 1, `evt_alt_int` is also 1. Armed edges that arrive while a request is pending do not leave a second request behind after the acknowledge.
- R11: An immediate access (`acc_ext`=0) decodes only `acc_addr[5:0]`. An extended access (`acc_ext`=1) to 00h..3Fh behaves exactly like the immediate access to the same address.
- R12: An extended access to 40h..FFh reads 00h and does not change the register. It raises `addr_err` for the one cycle that follows the access.
- R13: An access to any other address in 00h..3Fh reads 00h, changes nothing and does not raise `addr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Register access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | 1 = 8-bit extended address, 0 = immediate address |
| acc_addr | input | 8 | Access address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, registered |
| addr_err | output | 1 | One-cycle pulse after an access to an unimplemented extended address |
| sess_vld_raw | input | 1 | Asynchronous session-valid level |
| evt_req | output | 1 | Pending status-command request |
| evt_alt_int | output | 1 | Alternate-interrupt mark carried with the request |
| evt_ack | input | 1 | Serializer acknowledge that clears the request |

## Verification
The assertions assume that `sess_vld_raw` may change at any time and that `evt_ack` is only asserted after a request has been seen. They also assume that the access signals are stable around the clock edge. The stimulus drives every input at the falling edge. Register accesses use random extended and immediate addresses, which are weighted towards the three aliases and cover both the folded and the unimplemented ranges. Each session-valid toggle is held for at least five cycles so that the synchronizer latency can be checked exactly. The acknowledge is issued only after the expected request has been observed.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE  = 3'd0,
    ACC_READ  = 3'd1,
    ACC_LOAD  = 3'd2,
    ACC_SET   = 3'd3,
    ACC_CLEAR = 3'd4
  } acc_op_e;

  typedef struct packed {
    acc_op_e op;
    logic    hit;
    logic    bad;
  } acc_dec_t;

endpackage

// File: rtl/pcr_sync.sv
module pcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_d = d_async;
    end else begin : g_many
      always_comb pipe_d = {pipe_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/pcr_decode.sv
module pcr_decode
  import phy_ctl_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          IMM_AW    = 6,
  parameter logic [7:0]  BASE_ADDR = 8'h3D
) (
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_ext,
  input  logic [AW-1:0] acc_addr,
  output acc_dec_t      dec
);
  localparam logic [AW-1:0] A_LOAD  = AW'(BASE_ADDR);
  localparam logic [AW-1:0] A_SET   = AW'(BASE_ADDR + 8'd1);
  localparam logic [AW-1:0] A_CLEAR = AW'(BASE_ADDR + 8'd2);

  logic [AW-1:0] eff_addr;
  logic          upper_set;
  logic          is_load, is_set, is_clear;

  always_comb begin
    eff_addr  = {{(AW-IMM_AW){1'b0}}, acc_addr[IMM_AW-1:0]};
    upper_set = |acc_addr[AW-1:IMM_AW];
    is_load   = (eff_addr == A_LOAD);
    is_set    = (eff_addr == A_SET);
    is_clear  = (eff_addr == A_CLEAR);

    dec.bad = acc_valid && acc_ext && upper_set;
    dec.hit = acc_valid && !dec.bad && (is_load || is_set || is_clear);
    dec.op  = ACC_IDLE;
    if (acc_valid) begin
      if (!acc_write)        dec.op = ACC_READ;
      else if (dec.hit) begin
        if (is_load)         dec.op = ACC_LOAD;
        else if (is_set)     dec.op = ACC_SET;
        else                 dec.op = ACC_CLEAR;
      end
    end
  end
endmodule

// File: rtl/pcr_ctlreg.sv
module pcr_ctlreg
  import phy_ctl_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [7:0]  RW_MASK = 8'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_dec_t      dec,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] rd_data,
  output logic          addr_err
);
  localparam logic [DW-1:0] MASK = DW'(RW_MASK);

  logic [DW-1:0] ctl_d, rd_d;
  logic          ctl_en, rd_en, err_d;

  always_comb begin
    ctl_d  = ctl_q;
    ctl_en = 1'b0;
    case (dec.op)
      ACC_LOAD:  begin ctl_d = wdata & MASK;           ctl_en = 1'b1; end
      ACC_SET:   begin ctl_d = ctl_q | (wdata & MASK); ctl_en = 1'b1; end
      ACC_CLEAR: begin ctl_d = ctl_q & ~wdata;         ctl_en = 1'b1; end
      default:   begin ctl_d = ctl_q;                  ctl_en = 1'b0; end
    endcase
    rd_en = (dec.op == ACC_READ);
    rd_d  = dec.hit ? ctl_q : '0;
    err_d = dec.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      rd_data  <= '0;
      addr_err <= 1'b0;
    end else begin
      if (ctl_en) ctl_q   <= ctl_d;
      if (rd_en)  rd_data <= rd_d;
      addr_err <= err_d;
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.op == ACC_LOAD) |=> (ctl_q == ($past(wdata) & MASK)));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~MASK) == '0);
endmodule

// File: rtl/pcr_edge_evt.sv
module pcr_edge_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic sv_sync,
  input  logic en_rise,
  input  logic en_fall,
  input  logic ack,
  output logic req,
  output logic alt_int
);
  logic prev_q;
  logic rise, fall, armed, req_d;

  always_comb begin
    rise  = sv_sync & ~prev_q;
    fall  = ~sv_sync & prev_q;
    armed = (rise & en_rise) | (fall & en_fall);
    req_d = armed | (req & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      prev_q <= sv_sync;
      req    <= req_d;
    end
  end

  assign alt_int = req;

  // R7
  rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_sync && !prev_q && en_rise) |=> req);

  // R8
  fall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sv_sync && prev_q && en_fall) |=> req);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past((sv_sync != prev_q) && (en_rise || en_fall)));
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter int          IMM_AW      = 6,
  parameter logic [7:0]  BASE_ADDR   = 8'h3D,
  parameter int          RISE_BIT    = 2,
  parameter int          FALL_BIT    = 3,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_ext,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          addr_err,
  input  logic          sess_vld_raw,
  output logic          evt_req,
  output logic          evt_alt_int,
  input  logic          evt_ack
);
  localparam logic [7:0] RW_MASK = 8'((1 << RISE_BIT) | (1 << FALL_BIT));

  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  acc_dec_t      dec;
  logic [DW-1:0] ctl_q;
  logic          sv_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  pcr_decode #(.AW(AW), .IMM_AW(IMM_AW), .BASE_ADDR(BASE_ADDR)) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_ext   (acc_ext),
    .acc_addr  (acc_addr),
    .dec       (dec)
  );

  pcr_ctlreg #(.DW(DW), .RW_MASK(RW_MASK)) u_ctlreg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .dec      (dec),
    .wdata    (acc_wdata),
    .ctl_q    (ctl_q),
    .rd_data  (rd_data),
    .addr_err (addr_err)
  );

  pcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .d_async (sess_vld_raw),
    .q_sync  (sv_sync)
  );

  pcr_edge_evt u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sv_sync (sv_sync),
    .en_rise (ctl_q[RISE_BIT]),
    .en_fall (ctl_q[FALL_BIT]),
    .ack     (evt_ack),
    .req     (evt_req),
    .alt_int (evt_alt_int)
  );

  // R12
  bad_addr_err_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && acc_ext && (|acc_addr[AW-1:IMM_AW])) |=> addr_err);

  // R12
  bad_addr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (acc_valid && acc_write && acc_ext && (|acc_addr[AW-1:IMM_AW])) |=> $stable(ctl_q));

  // R6
  rd_reserved_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_data & ~DW'(RW_MASK)) == '0);

  // R10
  alt_mark_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    evt_req |-> evt_alt_int);
endmodule

// File: tb/phy_ctl_regbank_bench.sv
module phy_ctl_regbank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid, acc_write, acc_ext;
  logic [7:0] acc_addr, acc_wdata;
  logic [7:0] rd_data;
  logic       addr_err;
  logic       sess_vld_raw;
  logic       evt_req, evt_alt_int, evt_ack;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] model_reg;
  logic       sess_lvl;

  always #5ns clk = ~clk;

  phy_ctl_regbank u_phy_ctl_regbank (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_ext(acc_ext), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .addr_err(addr_err), .sess_vld_raw(sess_vld_raw),
    .evt_req(evt_req), .evt_alt_int(evt_alt_int), .evt_ack(evt_ack)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic exp_bad(input logic ext, input logic [7:0] a);
    return ext && (a >= 8'h40);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] r, input logic ext, input logic [7:0] a);
    logic [5:0] e;
    e = a[5:0];
    if (exp_bad(ext, a)) return 8'h00;
    if (e == 6'h3D || e == 6'h3E || e == 6'h3F) return r;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_write(input logic [7:0] r, input logic ext,
                                           input logic [7:0] a, input logic [7:0] d);
    if (exp_bad(ext, a)) return r;
    case (a[5:0])
      6'h3D:   return d & 8'h0C;
      6'h3E:   return r | (d & 8'h0C);
      6'h3F:   return r & ~d;
      default: return r;
    endcase
  endfunction

  task automatic access(input logic wr, input logic ext, input logic [7:0] a,
                        input logic [7:0] d, output logic [7:0] rd, output logic err);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_ext = ext; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    rd = rd_data; err = addr_err;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic do_op(input string req, input logic wr, input logic ext,
                       input logic [7:0] a, input logic [7:0] d);
    logic [7:0] rd;
    logic err;
    access(wr, ext, a, d, rd, err);
    if (!wr) chk(req, rd, exp_read(model_reg, ext, a));
    chk({req, " R12 err"}, {7'd0, err}, {7'd0, exp_bad(ext, a)});
    if (wr) model_reg = exp_write(model_reg, ext, a, d);
  endtask

  task automatic edge_trial(input string req, input logic en_r, input logic en_f);
    logic expv;
    do_op("R2", 1'b1, 1'b0, 8'h3D, {4'h0, en_f, en_r, 2'b00});
    sess_lvl = ~sess_lvl;
    expv = (sess_lvl && en_r) || (!sess_lvl && en_f);
    @(negedge clk); sess_vld_raw = sess_lvl;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({req, " early"}, {7'd0, evt_req}, 8'd0);
    @(posedge clk); @(negedge clk);
    chk(req, {7'd0, evt_req}, {7'd0, expv});
    chk("R10 alt", {7'd0, evt_alt_int}, {7'd0, expv});
    repeat (3) @(negedge clk);
    chk("R10 hold", {7'd0, evt_req}, {7'd0, expv});
    evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
    chk("R10 ack", {7'd0, evt_req}, 8'd0);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic err;
    process::self().srandom(32'h5EED_1504);
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_ext = 1'b0;
    acc_addr = 8'h00; acc_wdata = 8'h00; sess_vld_raw = 1'b0; evt_ack = 1'b0;
    sess_lvl = 1'b0; model_reg = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 req", {6'd0, evt_req, evt_alt_int}, 8'h00);
    chk("R1 err", {7'd0, addr_err}, 8'h00);
    do_op("R1 reg", 1'b0, 1'b0, 8'h3D, 8'h00);

    // R2 R6 load with reserved bits set
    do_op("R2", 1'b1, 1'b0, 8'h3D, 8'hFF);
    do_op("R6", 1'b0, 1'b0, 8'h3D, 8'h00);
    chk("R6 rd", rd_data, 8'h0C);
    // R4 clear
    do_op("R4", 1'b1, 1'b0, 8'h3F, 8'h04);
    do_op("R4", 1'b0, 1'b0, 8'h3F, 8'h00);
    // R3 set
    do_op("R3", 1'b1, 1'b0, 8'h3E, 8'hF7);
    do_op("R3", 1'b0, 1'b0, 8'h3E, 8'h00);
    // R5 reads at all aliases and hold
    do_op("R5", 1'b0, 1'b0, 8'h3D, 8'h00);
    do_op("R5", 1'b0, 1'b1, 8'h3F, 8'h00);
    repeat (2) @(negedge clk);
    chk("R5 hold", rd_data, model_reg);
    // R11 immediate folds upper bits
    do_op("R11", 1'b1, 1'b0, 8'hFD, 8'h08);
    do_op("R11", 1'b0, 1'b1, 8'h3E, 8'h00);
    // R12 unimplemented extended
    do_op("R12", 1'b1, 1'b1, 8'h7D, 8'h04);
    do_op("R12", 1'b0, 1'b1, 8'hBD, 8'h00);
    access(1'b0, 1'b1, 8'h3D, 8'h00, rd, err);
    chk("R12 pulse", {7'd0, addr_err}, 8'h00);
    chk("R12 nowrite", rd, model_reg);
    // R13 other in-range address
    do_op("R13", 1'b1, 1'b0, 8'h10, 8'hFF);
    do_op("R13", 1'b0, 1'b1, 8'h3C, 8'h00);
    do_op("R13", 1'b0, 1'b0, 8'h3D, 8'h00);

    // random register accesses
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 6)      a = 8'h3D + 8'($urandom_range(0, 2));
      else if (sel < 8) a = 8'($urandom_range(0, 255));
      else              a = 8'($urandom_range(64, 255));
      do_op("R5 R11 rand", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
            8'($urandom_range(0, 255)));
    end

    // directed edge cases
    edge_trial("R7", 1'b1, 1'b0);   // rise armed
    edge_trial("R9", 1'b1, 1'b0);   // fall not armed
    edge_trial("R9", 1'b0, 1'b1);   // rise not armed
    edge_trial("R8", 1'b0, 1'b1);   // fall armed

    // R10 merge: rise then fall while pending
    do_op("R10", 1'b1, 1'b0, 8'h3D, 8'h0C);
    @(negedge clk); sess_vld_raw = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 pend", {7'd0, evt_req}, 8'd1);
    sess_vld_raw = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 merged", {7'd0, evt_req}, 8'd1);
    evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 no second", {7'd0, evt_req}, 8'd0);
    sess_lvl = 1'b0;

    // random edge trials
    for (int i = 0; i < 40; i++) begin
      logic r, f;
      r = 1'($urandom_range(0, 1));
      f = 1'($urandom_range(0, 1));
      edge_trial(sess_lvl ? "R8 R9 rand" : "R7 R9 rand", r, f);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule